// File: doc/BRIEF.md
# Parity-Filtering Block Transfer Engine

This block moves a fixed burst of 40 bytes between a local byte buffer and an 8K-byte display storage RAM. The buffer sits in the CPU register space. Software fills the buffer or leaves it to be filled, loads a 13-bit start address and the transfer controls, then writes the start bit. A sequencer walks the RAM one byte per cycle, stepping the address up or down with wrap-around. When the burst is done it returns the buffer to the CPU.

A burst either copies RAM into the buffer (read) or copies the buffer into RAM (write). A write burst can filter its bytes. In reject mode, a byte with even parity is not stored and its RAM location keeps its old value. In cancel mode, the top bit of every stored byte is cleared. Both modes may be used together. In that case the parity test is made on the original byte, and only passing bytes are stored, each with the top bit cleared. A sticky flag records any byte with even parity seen during a write burst.

The sequencer has three states. IDLE waits for a launch. MOVE issues one RAM access per cycle. TAIL takes the last read return. The transitions are as follows. IDLE goes to MOVE on an accepted start. MOVE goes to TAIL after the access for byte 39. TAIL always returns to IDLE.

Top module: `burst_xfer_engine`

## Requirements
- R1: After reset the sequencer is in IDLE. All control fields, the start address and every buffer byte are 0, and neither RAM enable nor RAM write is asserted.
- R2: CPU offsets: 0..39 are the buffer bytes. 40 is the config register: bit0 global enable, bit1 read allowed, bit2 write allowed. 41 is the control register: bit0 busy/start, bit1 direction (1 = buffer to RAM), bit2 count down, bit3 parity reject, bit4 parity cancel, bit5 parity error. 42 holds start address bits 7:0 and 43 holds bits 12:8 in its bits 4:0. Reads of these offsets return the stored fields.
- R3: Writing 1 to control bit0 launches a burst only when the sequencer is idle, global enable is 1 and the chosen direction is allowed. Otherwise busy stays 0 and the RAM is not accessed. Control and address writes made during a burst are ignored.
- R4: A burst makes exactly 40 RAM accesses, one per cycle. Busy reads 1 for 41 cycles following the launching write edge, then clears by itself.
- R5: Byte i is transferred at the start address plus i, or minus i when counting down, taken modulo 8192.
- R6: In a read burst, buffer byte i receives the RAM byte at address i's location. The filter bits have no effect.
- R7: In a plain write burst, RAM receives each buffer byte unchanged.
- R8: A byte has good parity when it holds an odd number of ones. In reject mode, a byte with even parity is not written and the RAM location keeps its previous value.
- R9: In cancel mode, bit7 of each stored byte is 0. With reject also set, the parity test uses the original byte.
- R10: The parity-error bit is set by any even-parity byte during a write burst. It stays set until the CPU writes the control register with bit5 = 0 while idle.
- R11: While busy, CPU reads of the buffer return 0 and CPU writes to the buffer are ignored.
- R12: The read-allowed and write-allowed bits change only on a config write made while global enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | CPU register access strobe |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 6 | CPU register offset |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational, 0 when not selected |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 13 | RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after an enabled read |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume the RAM returns read data exactly one cycle after an enabled access, with no wait states. The bench RAM model is a read-first synchronous memory that never stalls. All CPU stimulus is applied between clock edges as single-cycle strobes, so each register write is sampled on exactly one edge.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MOVE,
        ST_TAIL
    } seq_state_t;

    localparam int CFG_OFS = 0;
    localparam int CTL_OFS = 1;
    localparam int ADL_OFS = 2;
    localparam int ADH_OFS = 3;
    localparam int NUM_CTRL_REGS = 4;
endpackage

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int LEN = 40,
    parameter int AW  = 13,
    parameter int IW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          dir_wr,
    input  logic          down,
    input  logic [AW-1:0] start_addr,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic          ram_en,
    output logic          ram_wr_req,
    output logic [AW-1:0] ram_addr,
    output logic          cap_v,
    output logic [IW-1:0] cap_idx
);
    localparam logic [IW-1:0] LAST = IW'(LEN - 1);

    seq_state_t    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [AW-1:0] ptr_q;
    logic          cap_v_q;
    logic [IW-1:0] cap_idx_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (launch) state_d = ST_MOVE;
            ST_MOVE: if (idx_q == LAST) state_d = ST_TAIL;
            ST_TAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // byte counter, address pointer and read-return tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            ptr_q     <= '0;
            cap_v_q   <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            if (launch && state_q == ST_IDLE) begin
                idx_q <= '0;
                ptr_q <= start_addr;
            end else if (state_q == ST_MOVE) begin
                idx_q <= idx_q + 1'b1;
                ptr_q <= down ? ptr_q - 1'b1 : ptr_q + 1'b1;
            end
            cap_v_q   <= (state_q == ST_MOVE) && !dir_wr;
            cap_idx_q <= idx_q;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        ram_en     = (state_q == ST_MOVE);
        ram_wr_req = (state_q == ST_MOVE) && dir_wr;
        ram_addr   = ptr_q;
        idx        = idx_q;
        cap_v      = cap_v_q;
        cap_idx    = cap_idx_q;
    end

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && $past(ram_en)) |->
        (ram_addr == (down ? $past(ram_addr) - 1'b1 : $past(ram_addr) + 1'b1)));

    a_r4_tail_after_move: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAIL) |-> ($past(state_q) == ST_MOVE && $past(idx_q) == LAST));

    a_r4_move_starts_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MOVE && $past(state_q) == ST_IDLE) |-> (idx_q == '0));
endmodule

// File: rtl/parity_gate.sv
module parity_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         reject,
    input  logic         cancel,
    output logic         odd,
    output logic         pass,
    output logic [W-1:0] dout
);
    always_comb begin
        odd  = ^din;
        pass = !reject || odd;
        dout = din;
        if (cancel) dout[W-1] = 1'b0;
    end
endmodule

// File: rtl/buf_bank.sv
module buf_bank #(
    parameter int DEPTH = 40,
    parameter int W     = 8,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_we,
    input  logic [IW-1:0] cpu_idx,
    input  logic [W-1:0]  cpu_wdata,
    input  logic          eng_we,
    input  logic [IW-1:0] eng_idx,
    input  logic [W-1:0]  eng_wdata,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a_data,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b_data
);
    logic [W-1:0]     mem [DEPTH];
    logic [DEPTH-1:0] eng_hit;
    logic [DEPTH-1:0] cpu_hit;

    for (genvar i = 0; i < DEPTH; i++) begin : g_dec
        assign eng_hit[i] = eng_we && (eng_idx == IW'(i));
        assign cpu_hit[i] = cpu_we && (cpu_idx == IW'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (eng_hit[i])      mem[i] <= eng_wdata;
                else if (cpu_hit[i]) mem[i] <= cpu_wdata;
            end
        end
    end

    always_comb begin
        rd_a_data = (int'(rd_a_idx) < DEPTH) ? mem[rd_a_idx] : '0;
        rd_b_data = (int'(rd_b_idx) < DEPTH) ? mem[rd_b_idx] : '0;
    end

    a_r11_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eng_hit) + $countones(cpu_hit) <= 1);
endmodule

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine
    import xfer_pkg::*;
#(
    parameter int LEN    = 40,
    parameter int AW     = 13,
    parameter int DW     = 8,
    parameter int CPU_AW = $clog2(LEN + NUM_CTRL_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DW-1:0]     ram_wdata,
    input  logic [DW-1:0]     ram_rdata
);
    localparam int IW = $clog2(LEN);
    localparam logic [CPU_AW-1:0] A_CFG = CPU_AW'(LEN + CFG_OFS);
    localparam logic [CPU_AW-1:0] A_CTL = CPU_AW'(LEN + CTL_OFS);
    localparam logic [CPU_AW-1:0] A_ADL = CPU_AW'(LEN + ADL_OFS);
    localparam logic [CPU_AW-1:0] A_ADH = CPU_AW'(LEN + ADH_OFS);
    localparam int HI_W = AW - 8;

    logic          gen_q, rd_ok_q, wr_ok_q;
    logic          dir_q, down_q, rej_q, can_q, perr_q;
    logic [AW-1:0] sa_q;

    logic          busy, ram_wr_req, cap_v, launch;
    logic [IW-1:0] eng_idx, cap_idx;
    logic [DW-1:0] eng_byte, cpu_buf_byte;
    logic          odd, pass;
    logic          cpu_wr, hit_buf, cfg_wr, ctl_wr, adl_wr, adh_wr;

    always_comb begin
        cpu_wr  = cpu_sel && cpu_we;
        hit_buf = (cpu_addr < CPU_AW'(LEN));
        cfg_wr  = cpu_wr && (cpu_addr == A_CFG);
        ctl_wr  = cpu_wr && (cpu_addr == A_CTL);
        adl_wr  = cpu_wr && (cpu_addr == A_ADL) && !busy;
        adh_wr  = cpu_wr && (cpu_addr == A_ADH) && !busy;
        launch  = ctl_wr && !busy && cpu_wdata[0] && gen_q &&
                  (cpu_wdata[1] ? wr_ok_q : rd_ok_q);
    end

    xfer_seq #(.LEN(LEN), .AW(AW), .IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .dir_wr     (dir_q),
        .down       (down_q),
        .start_addr (sa_q),
        .busy       (busy),
        .idx        (eng_idx),
        .ram_en     (ram_en),
        .ram_wr_req (ram_wr_req),
        .ram_addr   (ram_addr),
        .cap_v      (cap_v),
        .cap_idx    (cap_idx)
    );

    buf_bank #(.DEPTH(LEN), .W(DW), .IW(IW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_we    (cpu_wr && hit_buf && !busy),
        .cpu_idx   (IW'(cpu_addr)),
        .cpu_wdata (cpu_wdata),
        .eng_we    (cap_v),
        .eng_idx   (cap_idx),
        .eng_wdata (ram_rdata),
        .rd_a_idx  (IW'(cpu_addr)),
        .rd_a_data (cpu_buf_byte),
        .rd_b_idx  (eng_idx),
        .rd_b_data (eng_byte)
    );

    parity_gate #(.W(DW)) u_gate (
        .din    (eng_byte),
        .reject (rej_q),
        .cancel (can_q),
        .odd    (odd),
        .pass   (pass),
        .dout   (ram_wdata)
    );

    assign ram_we = ram_wr_req && pass;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q   <= 1'b0;
            rd_ok_q <= 1'b0;
            wr_ok_q <= 1'b0;
            dir_q   <= 1'b0;
            down_q  <= 1'b0;
            rej_q   <= 1'b0;
            can_q   <= 1'b0;
            perr_q  <= 1'b0;
            sa_q    <= '0;
        end else begin
            if (cfg_wr) begin
                gen_q <= cpu_wdata[0];
                if (!gen_q) begin
                    rd_ok_q <= cpu_wdata[1];
                    wr_ok_q <= cpu_wdata[2];
                end
            end
            if (ctl_wr && !busy) begin
                dir_q  <= cpu_wdata[1];
                down_q <= cpu_wdata[2];
                rej_q  <= cpu_wdata[3];
                can_q  <= cpu_wdata[4];
                perr_q <= perr_q && cpu_wdata[5];
            end else if (ram_wr_req && !odd) begin
                perr_q <= 1'b1;
            end
            if (adl_wr) sa_q[7:0]  <= cpu_wdata[7:0];
            if (adh_wr) sa_q[AW-1:8] <= cpu_wdata[HI_W-1:0];
        end
    end

    always_comb begin
        cpu_rdata = '0;
        if (cpu_sel) begin
            if (hit_buf) begin
                cpu_rdata = busy ? '0 : cpu_buf_byte;
            end else begin
                case (cpu_addr)
                    A_CFG:   cpu_rdata = {5'b0, wr_ok_q, rd_ok_q, gen_q};
                    A_CTL:   cpu_rdata = {2'b0, perr_q, can_q, rej_q, down_q, dir_q, busy};
                    A_ADL:   cpu_rdata = sa_q[7:0];
                    A_ADH:   cpu_rdata = DW'(sa_q[AW-1:8]);
                    default: cpu_rdata = '0;
                endcase
            end
        end
    end

    a_r3_launch_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(gen_q));

    a_r8_reject_keeps_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && rej_q && !can_q) |-> ((^ram_wdata) == 1'b1));

    a_r9_cancel_clears_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && can_q) |-> (ram_wdata[DW-1] == 1'b0));

    a_r10_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(perr_q) && !$past(ctl_wr)) |-> perr_q);

    a_r12_allow_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gen_q) |-> ($stable(rd_ok_q) && $stable(wr_ok_q)));

    a_r11_write_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (busy && dir_q));
endmodule

// File: tb/burst_xfer_engine_bench.sv
module burst_xfer_engine_bench;
    localparam int LEN = 40;
    localparam int NV  = 7;
    localparam logic [5:0] O_CFG = 6'd40, O_CTL = 6'd41, O_ADL = 6'd42, O_ADH = 6'd43;

    // {down, reject, cancel, write, addr[12:0], seed[7:0]}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 13'h0100, 8'h11},
        {1'b0, 1'b0, 1'b0, 1'b1, 13'h0200, 8'h23},
        {1'b0, 1'b1, 1'b0, 1'b1, 13'h0300, 8'h35},
        {1'b1, 1'b0, 1'b1, 1'b1, 13'h0410, 8'h47},
        {1'b0, 1'b1, 1'b1, 1'b1, 13'h1FF0, 8'h59},
        {1'b1, 1'b0, 1'b0, 1'b0, 13'h0005, 8'h6B},
        {1'b1, 1'b0, 1'b0, 1'b1, 13'h0003, 8'h7D}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_we = 1'b0;
    logic [5:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        ram_en, ram_we;
    logic [12:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic [7:0]  ram_rdata = '0;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] mem [int];

    always #10 clk = ~clk;

    burst_xfer_engine u_burst_xfer_engine (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    function automatic logic [7:0] rdm(input logic [12:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    function automatic logic [7:0] pat(input int i, input logic [7:0] seed);
        logic [7:0] p;
        p = seed + 8'(i * 29);
        if (i % 3 == 0) p = p ^ 8'h80;
        return p;
    endfunction

    function automatic logic [12:0] step(input logic [12:0] a, input int i, input logic dn);
        return dn ? a - 13'(i) : a + 13'(i);
    endfunction

    // read-first synchronous RAM model
    always @(posedge clk) begin
        if (ram_en) begin
            logic [7:0] t;
            t = rdm(ram_addr);
            ram_rdata <= t;
            if (ram_we) mem[int'(ram_addr)] = ram_wdata;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic cpu_rd(input logic [5:0] a, output logic [7:0] d);
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] c;
        for (int k = 0; k < 200; k++) begin
            cpu_rd(O_CTL, c);
            if (!c[0]) break;
        end
    endtask

    task automatic set_addr(input logic [12:0] a);
        cpu_wr(O_ADL, a[7:0]);
        cpu_wr(O_ADH, {3'b0, a[12:8]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] pre [LEN];
        logic [7:0] b [LEN];
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        cpu_rd(O_CTL, d); chk("R1 ctl after reset", d, 8'h00);
        cpu_rd(O_CFG, d); chk("R1 cfg after reset", d, 8'h00);
        cpu_rd(6'd0, d);  chk("R1 buffer after reset", d, 8'h00);
        chk("R1 ram idle", {6'b0, ram_en, ram_we}, 8'h00);

        // R3: start ignored while global enable is 0
        cpu_wr(O_CFG, 8'h06);
        cpu_rd(O_CFG, d); chk("R2 cfg readback", d, 8'h06);
        set_addr(13'h0A00);
        cpu_rd(O_ADH, d); chk("R2 addr high readback", d, 8'h0A);
        cpu_wr(6'd0, 8'h5B);
        cpu_wr(O_CTL, 8'h03);
        cpu_rd(O_CTL, d); chk("R3 no launch when disabled", d, 8'h02);
        repeat (45) @(negedge clk);
        chk("R3 ram untouched", rdm(13'h0A00), 8'h00 ^ {5'h0A, 3'b101});

        // R3: direction not allowed
        cpu_wr(O_CFG, 8'h03);
        cpu_wr(O_CTL, 8'h03);
        cpu_rd(O_CTL, d); chk("R3 no launch when write disallowed", d[0], 1'b0);
        repeat (45) @(negedge clk);
        chk("R3 ram untouched 2", rdm(13'h0A00), 8'h00 ^ {5'h0A, 3'b101});

        // R12: allow bits locked while enabled
        cpu_wr(O_CFG, 8'h05);
        cpu_rd(O_CFG, d); chk("R12 locked while enabled", d, 8'h03);
        cpu_wr(O_CFG, 8'h00);
        cpu_rd(O_CFG, d); chk("R12 disable keeps allow", d, 8'h02);
        cpu_wr(O_CFG, 8'h07);
        cpu_rd(O_CFG, d); chk("R12 update while disabled", d, 8'h07);

        // vector table: R5..R10
        for (int v = 0; v < NV; v++) begin
            logic dn, rj, cn, wr, any_bad;
            logic [12:0] sa;
            logic [7:0] sd, e;
            {dn, rj, cn, wr, sa, sd} = VEC[v];
            any_bad = 1'b0;
            for (int i = 0; i < LEN; i++) begin
                b[i] = pat(i, sd);
                cpu_wr(6'(i), b[i]);
                pre[i] = rdm(step(sa, i, dn));
            end
            set_addr(sa);
            cpu_wr(O_CTL, 8'h00);
            cpu_wr(O_CTL, {3'b0, cn, rj, dn, wr, 1'b1});
            wait_idle();
            for (int i = 0; i < LEN; i++) begin
                if (wr) begin
                    e = b[i];
                    if (!(^b[i])) any_bad = 1'b1;
                    if (rj && !(^b[i])) e = pre[i];
                    else if (cn) e[7] = 1'b0;
                    chk(rj ? "R8 reject write" : (cn ? "R9 cancel write" : "R7 plain write"),
                        rdm(step(sa, i, dn)), e);
                end else begin
                    cpu_rd(6'(i), d);
                    chk("R6 read burst R5 address", d, pre[i]);
                end
            end
            cpu_rd(O_CTL, d);
            chk("R10 perr after burst", d[5], any_bad);
        end

        // R11 and R4: buffer blocked while busy, busy length
        for (int i = 0; i < LEN; i++) cpu_wr(6'(i), 8'h07 + 8'(i));
        set_addr(13'h0C00);
        cpu_wr(O_CTL, 8'h03);
        cpu_rd(6'd0, d);  chk("R11 buffer read blocked", d, 8'h00);
        cpu_wr(6'd2, 8'hEE);
        cpu_wr(O_ADL, 8'h55);
        wait_idle();
        cpu_rd(6'd2, d);  chk("R11 buffer write ignored", d, 8'h09);
        chk("R11 ram got original", rdm(13'h0C02), 8'h09);
        cpu_rd(O_ADL, d); chk("R3 address write ignored while busy", d, 8'h00);

        set_addr(13'h0D00);
        cpu_wr(O_CTL, 8'h03);
        cnt = 0;
        cpu_sel = 1'b1; cpu_we = 1'b0; cpu_addr = O_CTL;
        for (int k = 0; k < 100; k++) begin
            #1;
            if (!cpu_rdata[0]) break;
            cnt++;
            @(negedge clk);
        end
        cpu_sel = 1'b0;
        chk("R4 busy cycles", 8'(cnt), 8'(LEN + 1));

        // R10: sticky flag
        cpu_wr(6'd0, 8'h03);
        set_addr(13'h0E00);
        cpu_wr(O_CTL, 8'h00);
        cpu_wr(O_CTL, 8'h0B);
        wait_idle();
        cpu_rd(O_CTL, d); chk("R10 perr set", d[5], 1'b1);
        chk("R8 even byte rejected", rdm(13'h0E00), 8'h00 ^ {5'h0E, 3'b101});
        cpu_wr(O_CTL, 8'h21);
        wait_idle();
        cpu_rd(O_CTL, d); chk("R10 perr survives read burst", d[5], 1'b1);
        cpu_wr(O_CTL, 8'h20);
        cpu_rd(O_CTL, d); chk("R10 perr kept by write of 1", d[5], 1'b1);
        cpu_wr(O_CTL, 8'h00);
        cpu_rd(O_CTL, d); chk("R10 perr cleared", d[5], 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule